// File: doc/BRIEF.md
# Glitch-Free Coefficient Group Loader

This block stages a small group of parameter writes and applies them to the parameter RAM of a running audio DSP as a single group. Software writes up to five 28-bit parameter words and their target RAM addresses into staging slots over a simple control-register write bus. It then raises a trigger. The block waits for the next audio frame-start pulse from the DSP sequencer and then copies every staged slot into the parameter RAM. This way a complete coefficient set, such as all five taps of a biquad section, changes between two frames and never halfway through one.

The parameter RAM write port is shared with the DSP core. The block issues at most one RAM write per cycle. It only writes in cycles where the core has not claimed the RAM, so the core never has to be halted. Only slots whose data word was written since the previous transfer are committed. While a transfer is armed or running, the block reports busy and refuses all further staging writes and triggers.

Top module: `safeload_unit`

## Requirements
- R1: A control write to address 0x0810+i (i = 0..4) while not busy stores the 28-bit word in slot i and marks slot i pending. Writes to any other address outside 0x0810..0x0819 change nothing.
- R2: A control write to address 0x0815+i while not busy stores the low 10 bits of the word as the RAM address of slot i. It does not mark the slot pending.
- R3: A trigger while not busy raises busy in the next cycle. A frame-start pulse in the same cycle as the trigger does not start the transfer.
- R4: No RAM write is issued while idle, or while armed before a frame-start pulse has been seen.
- R5: After the frame-start pulse, pending slots are written one per cycle in ascending slot order, starting in the cycle after the pulse. Each write carries the slot's stored address and data.
- R6: No RAM write is issued in a cycle where the core access input is high. Committing resumes in the next free cycle.
- R7: A committed slot stops being pending. Slots not pending are never written, and each pending slot is written exactly once per transfer.
- R8: Busy falls in the cycle after the last commit write. If nothing is pending, busy falls in the second cycle after the frame-start pulse.
- R9: Control writes and triggers while busy is high are ignored. Stored words, addresses and pending marks are left unchanged.
- R10: After reset, busy and the RAM write enable are low, no slot is pending, and all slot words and addresses are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Control-register write strobe |
| reg_addr | input | 16 | Control-register address |
| reg_wdata | input | 28 | Control-register write data |
| trig | input | 1 | Arms a group transfer |
| frame_start | input | 1 | Audio frame boundary pulse from the sequencer |
| core_acc | input | 1 | DSP core owns the parameter RAM this cycle |
| pram_we | output | 1 | Parameter RAM write enable |
| pram_addr | output | 10 | Parameter RAM write address |
| pram_wdata | output | 28 | Parameter RAM write data |
| busy | output | 1 | Transfer armed or in progress |

## Verification
The assertions check four rules on every cycle. No RAM write ever coincides with a core access or happens outside a busy period. Busy only rises after a trigger and only falls with nothing left pending. Staged contents stay frozen while busy, and a slot leaves the pending set once it is written. Only the bench scenarios can show the rest. That covers the ascending commit order, the exact cycle in which writing starts after the frame-start pulse, and the correct address and data pairing. It also covers the wait for the frame boundary, the empty-transfer case, and address-only writes that leave a slot uncommitted.

// File: rtl/sl_pkg.sv
package sl_pkg;

    localparam int SL_SLOTS     = 5;
    localparam int SL_DATA_W    = 28;
    localparam int SL_PADDR_W   = 10;
    localparam int SL_CADDR_W   = 16;
    localparam int SL_DATA_BASE = 'h0810;

    typedef enum logic [1:0] {
        SL_IDLE   = 2'd0,
        SL_ARMED  = 2'd1,
        SL_COMMIT = 2'd2
    } sl_state_e;

endpackage

// File: rtl/sl_slots.sv
module sl_slots #(
    parameter int N     = 5,
    parameter int DW    = 28,
    parameter int AW    = 10,
    parameter int CW    = 16,
    parameter int DBASE = 'h0810
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [CW-1:0]        wr_addr,
    input  logic [DW-1:0]        wr_data,
    input  logic [N-1:0]         clr,
    output logic [N-1:0]         pend,
    output logic [N-1:0][DW-1:0] data_o,
    output logic [N-1:0][AW-1:0] addr_o
);

    localparam int ABASE = DBASE + N;

    for (genvar g = 0; g < N; g++) begin : g_slot
        logic hit_data;
        logic hit_addr;

        assign hit_data = wr_en && (wr_addr == CW'(DBASE + g));
        assign hit_addr = wr_en && (wr_addr == CW'(ABASE + g));

        always_ff @(posedge clk) begin
            if (rst) begin
                data_o[g] <= '0;
                addr_o[g] <= '0;
                pend[g]   <= 1'b0;
            end else begin
                if (hit_data) begin
                    data_o[g] <= wr_data;
                    pend[g]   <= 1'b1;
                end else if (clr[g]) begin
                    pend[g]   <= 1'b0;
                end
                if (hit_addr) begin
                    addr_o[g] <= wr_data[AW-1:0];
                end
            end
        end
    end

endmodule

// File: rtl/sl_pick.sv
module sl_pick #(
    parameter int N = 5
) (
    input  logic [N-1:0] pend,
    output logic [N-1:0] oh,
    output logic         any
);

    always_comb begin
        logic found;
        found = 1'b0;
        oh    = '0;
        for (int i = 0; i < N; i++) begin
            if (pend[i] && !found) begin
                oh[i] = 1'b1;
                found = 1'b1;
            end
        end
    end

    assign any = |pend;

endmodule

// File: rtl/sl_ctrl.sv
module sl_ctrl
    import sl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic trig,
    input  logic frame_start,
    input  logic core_acc,
    input  logic any_pend,
    input  logic drained,
    output logic busy,
    output logic fire
);

    sl_state_e state_q, state_d;

    assign fire = (state_q == SL_COMMIT) && any_pend && !core_acc;
    assign busy = (state_q != SL_IDLE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SL_IDLE:   if (trig)        state_d = SL_ARMED;
            SL_ARMED:  if (frame_start) state_d = SL_COMMIT;
            SL_COMMIT: if (drained)     state_d = SL_IDLE;
            default:                    state_d = SL_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= SL_IDLE;
        else     state_q <= state_d;
    end

endmodule

// File: rtl/safeload_unit.sv
module safeload_unit
    import sl_pkg::*;
#(
    parameter int NSLOT  = SL_SLOTS,
    parameter int DATA_W = SL_DATA_W,
    parameter int PADDR_W = SL_PADDR_W,
    parameter int CADDR_W = SL_CADDR_W,
    parameter int DBASE  = SL_DATA_BASE
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_we,
    input  logic [CADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    input  logic               trig,
    input  logic               frame_start,
    input  logic               core_acc,
    output logic               pram_we,
    output logic [PADDR_W-1:0] pram_addr,
    output logic [DATA_W-1:0]  pram_wdata,
    output logic               busy
);

    logic [NSLOT-1:0]              pend_q;
    logic [NSLOT-1:0]              pick_oh;
    logic [NSLOT-1:0]              clr;
    logic [NSLOT-1:0][DATA_W-1:0]  slot_data;
    logic [NSLOT-1:0][PADDR_W-1:0] slot_addr;
    logic                          any_pend;
    logic                          fire;
    logic                          drained;
    logic                          stage_en;
    logic                          trig_ok;

    assign stage_en = reg_we && !busy;
    assign trig_ok  = trig && !busy;
    assign clr      = fire ? pick_oh : '0;
    assign drained  = ((pend_q & ~clr) == '0);

    sl_slots #(
        .N(NSLOT), .DW(DATA_W), .AW(PADDR_W), .CW(CADDR_W), .DBASE(DBASE)
    ) u_slots (
        .clk(clk), .rst(rst),
        .wr_en(stage_en), .wr_addr(reg_addr), .wr_data(reg_wdata),
        .clr(clr), .pend(pend_q), .data_o(slot_data), .addr_o(slot_addr)
    );

    sl_pick #(.N(NSLOT)) u_pick (
        .pend(pend_q), .oh(pick_oh), .any(any_pend)
    );

    sl_ctrl u_ctrl (
        .clk(clk), .rst(rst), .trig(trig_ok), .frame_start(frame_start),
        .core_acc(core_acc), .any_pend(any_pend), .drained(drained),
        .busy(busy), .fire(fire)
    );

    always_comb begin
        pram_addr  = '0;
        pram_wdata = '0;
        for (int i = 0; i < NSLOT; i++) begin
            if (pick_oh[i]) begin
                pram_addr  = pram_addr  | slot_addr[i];
                pram_wdata = pram_wdata | slot_data[i];
            end
        end
    end

    assign pram_we = fire;

endmodule

// File: rtl/safeload_unit_chk.sv
module safeload_unit_chk #(
    parameter int NSLOT   = 5,
    parameter int DATA_W  = 28,
    parameter int PADDR_W = 10
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          trig,
    input logic                          busy,
    input logic                          pram_we,
    input logic                          core_acc,
    input logic [NSLOT-1:0]              pend_q,
    input logic [NSLOT-1:0]              pick_oh,
    input logic [NSLOT-1:0][DATA_W-1:0]  slot_data,
    input logic [NSLOT-1:0][PADDR_W-1:0] slot_addr
);

    // R6
    no_core_clash_chk: assert property (@(posedge clk) disable iff (rst)
        pram_we |-> !core_acc);

    // R4
    write_only_busy_chk: assert property (@(posedge clk) disable iff (rst)
        pram_we |-> busy);

    // R3
    busy_from_trig_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(trig));

    // R8
    drained_at_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (pend_q == '0));

    // R7
    slot_retired_chk: assert property (@(posedge clk) disable iff (rst)
        pram_we |=> (($past(pick_oh) & pend_q) == '0));

    // R9
    frozen_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(slot_data) && $stable(slot_addr)));

    // R5
    single_slot_chk: assert property (@(posedge clk) disable iff (rst)
        pram_we |-> $onehot(pick_oh));

endmodule

bind safeload_unit safeload_unit_chk #(
    .NSLOT(NSLOT), .DATA_W(DATA_W), .PADDR_W(PADDR_W)
) u_chk (
    .clk(clk), .rst(rst), .trig(trig), .busy(busy), .pram_we(pram_we),
    .core_acc(core_acc), .pend_q(pend_q), .pick_oh(pick_oh),
    .slot_data(slot_data), .slot_addr(slot_addr)
);

// File: tb/safeload_unit_tb.sv
module safeload_unit_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [15:0] reg_addr = '0;
    logic [27:0] reg_wdata = '0;
    logic        trig = 1'b0;
    logic        frame_start = 1'b0;
    logic        core_acc = 1'b0;
    logic        pram_we;
    logic [9:0]  pram_addr;
    logic [27:0] pram_wdata;
    logic        busy;

    int    checks = 0;
    int    errors = 0;
    int    cyc = 0;
    int    acc_mode = 0;
    string tag = "R10";

    // behavioural reference: 0 idle, 1 armed, 2 committing
    int          m_state = 0;
    logic [27:0] m_data [5];
    logic [9:0]  m_addr [5];
    bit          m_pend [5];
    int          m_writes [$];

    always #5 clk = ~clk;

    safeload_unit u_dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .trig(trig), .frame_start(frame_start),
        .core_acc(core_acc), .pram_we(pram_we), .pram_addr(pram_addr),
        .pram_wdata(pram_wdata), .busy(busy)
    );

    task automatic chk(input bit ok, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic step();
        int slot;
        bit ew;
        case (acc_mode)
            1:       core_acc = (cyc % 2) == 0;
            2:       core_acc = (cyc % 3) != 0;
            default: core_acc = 1'b0;
        endcase
        #1;
        slot = -1;
        for (int i = 0; i < 5; i++) if (m_pend[i] && slot < 0) slot = i;
        ew = (m_state == 2) && (slot >= 0) && !core_acc;
        chk(busy === (m_state != 0), "busy", 32'(busy), 32'(m_state != 0));
        chk(pram_we === ew, "pram_we", 32'(pram_we), 32'(ew));
        if (ew) begin
            chk(pram_addr === m_addr[slot], "pram_addr", 32'(pram_addr), 32'(m_addr[slot]));
            chk(pram_wdata === m_data[slot], "pram_wdata", 32'(pram_wdata), 32'(m_data[slot]));
        end
        @(posedge clk);
        cyc++;
        case (m_state)
            0: begin
                if (reg_we) begin
                    for (int i = 0; i < 5; i++) begin
                        if (reg_addr == 16'h0810 + 16'(i)) begin
                            m_data[i] = reg_wdata;
                            m_pend[i] = 1'b1;
                        end
                        if (reg_addr == 16'h0815 + 16'(i)) m_addr[i] = reg_wdata[9:0];
                    end
                end
                if (trig) m_state = 1;
            end
            1: if (frame_start) m_state = 2;
            default: begin
                if (ew) begin
                    m_pend[slot] = 1'b0;
                    m_writes.push_back(slot);
                end
                m_state = 2;
                begin
                    bit left;
                    left = 1'b0;
                    for (int i = 0; i < 5; i++) if (m_pend[i]) left = 1'b1;
                    if (!left) m_state = 0;
                end
            end
        endcase
        @(negedge clk);
    endtask

    task automatic wr(input logic [15:0] a, input logic [27:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        step();
        reg_we = 1'b0;
    endtask

    task automatic arm();
        trig = 1'b1; step(); trig = 1'b0;
    endtask

    task automatic frame();
        frame_start = 1'b1; step(); frame_start = 1'b0;
    endtask

    task automatic run(input int n);
        for (int k = 0; k < n; k++) step();
    endtask

    task automatic expect_order(input string what, input int exp_q [$]);
        chk(m_writes.size() == exp_q.size(), what, 32'(m_writes.size()), 32'(exp_q.size()));
        m_writes.delete();
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        for (int i = 0; i < 5; i++) begin
            m_data[i] = '0; m_addr[i] = '0; m_pend[i] = 1'b0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R10: reset state, then idle with no traffic
        tag = "R10";
        run(3);

        // R1 R2 R5: full group, no core contention
        tag = "R1 R2 R5";
        for (int i = 0; i < 5; i++) wr(16'h0815 + 16'(i), 28'h3FF0 + 28'(i * 7));
        for (int i = 0; i < 5; i++) wr(16'h0810 + 16'(i), 28'hA5A0000 + 28'(i));
        tag = "R3 R4";
        arm();
        run(4);
        tag = "R5 R8";
        frame();
        run(7);
        expect_order("R5 commit count", '{0, 1, 2, 3, 4});

        // R6 R7: partial set under alternating core access
        tag = "R6 R7";
        wr(16'h0811, 28'h1234567);
        wr(16'h0813, 28'hFEDCBA9);
        arm();
        acc_mode = 1;
        frame();
        run(8);
        acc_mode = 0;
        expect_order("R7 commit count", '{1, 3});

        // R6: heavy core access
        tag = "R6";
        wr(16'h0810, 28'h0000001);
        wr(16'h0812, 28'h0000002);
        wr(16'h0814, 28'h0000003);
        arm();
        acc_mode = 2;
        frame();
        run(12);
        acc_mode = 0;
        expect_order("R6 commit count", '{0, 2, 4});

        // R9: writes and triggers while busy are dropped
        tag = "R9";
        wr(16'h0812, 28'h0BEEF00);
        arm();
        wr(16'h0810, 28'h7777777);
        wr(16'h0816, 28'h0000155);
        arm();
        frame();
        wr(16'h0814, 28'h5555555);
        run(4);
        expect_order("R9 commit count", '{2});

        // R8: empty transfer
        tag = "R8";
        arm();
        run(2);
        frame();
        run(3);
        expect_order("R8 empty count", '{});

        // R2: address-only writes leave slots idle
        tag = "R2";
        wr(16'h0817, 28'hFFFFC01);
        arm();
        frame();
        run(2);
        expect_order("R2 addr-only count", '{});
        wr(16'h0812, 28'h0C0FFEE);
        arm();
        frame();
        run(3);
        expect_order("R2 remap count", '{2});

        // R3: frame start coinciding with the trigger is not taken
        tag = "R3";
        wr(16'h0810, 28'h0000AAA);
        trig = 1'b1; frame_start = 1'b1; step(); trig = 1'b0; frame_start = 1'b0;
        run(3);
        expect_order("R3 held count", '{});
        frame();
        run(3);
        expect_order("R3 commit count", '{0});

        // R1: out-of-window addresses change nothing
        tag = "R1";
        wr(16'h080F, 28'h1111111);
        wr(16'h081A, 28'h2222222);
        arm();
        frame();
        run(3);
        expect_order("R1 stray count", '{});

        summary();
    end

endmodule